// File: doc/BRIEF.md
# Fan drive ramp rate limiter

This block sits between a programmed target fan drive value and the drive value that is actually applied to the fan. When ramp limiting is switched on and the driver runs in one of the direct-setting modes, the applied value approaches the target in bounded increments. At most one increment is taken per update period. A 3-bit code picks the period from a fixed set of eight millisecond values, and a 1 ms tick paces the period.

When limiting is off, or the driver is in any other mode, the target is copied to the output on the next clock. A move toward the target never passes it. A maximum step of zero still lets the ramp advance by one count. A new target during a ramp takes effect from the present applied value, and the period already under way keeps running.

Top module: `fan_ramp_limiter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the applied drive is 0x00.
- R2: With `ramp_en` low, `drive` equals the value `target` held at the previous rising clock edge. This also holds when limiting is turned off in the middle of a ramp.
- R3: With `direct_mode` low (a mode that is not a direct-setting mode), `drive` follows `target` one clock later, whatever the value of `ramp_en`.
- R4: While limiting is active (`ramp_en` and `direct_mode` both high), two consecutive values of `drive` never differ by more than the effective step. The effective step is `max_step`, or 1 when `max_step` is 0.
- R5: When the distance to the target is no larger than the effective step, the step lands exactly on `target`, and `drive` never passes the target.
- R6: A `max_step` of 0x00 moves `drive` by exactly one count per update period.
- R7: `period_sel` selects the update period in 1 ms ticks: 0→100, 1→200, 2→300, 3→400, 4→500, 5→800, 6→1200, 7→1600. A step is taken on the tick that completes that count.
- R8: While limiting is active, `drive` changes only on a clock where `tick_ms` is high. The period counter reloads after every step.
- R9: Changing `target` during a ramp does not restart the period counter. The next step comes when the period already under way completes.
- R10: When a period completes on the same clock that `target` changes, that step moves toward the new target.
- R11: While limiting is inactive, the period counter is held at zero. The first step after limiting is enabled therefore comes a full period later, and enabling limiting produces no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| target | input | 8 | Programmed target drive setting |
| ramp_en | input | 1 | Ramp limiting enable (0 after reset in the configuration) |
| direct_mode | input | 1 | High when the driver is in a direct-setting mode |
| max_step | input | 8 | Largest change allowed per update |
| period_sel | input | 3 | Update period code (see R7) |
| tick_ms | input | 1 | One-clock pulse per millisecond |
| drive | output | 8 | Applied drive setting |

## Verification
Two functions can act on the same clock: completion of an update period, and a change of the target. To provoke the overlap, the bench steps the counter to one tick short of the period. It then raises `tick_ms` in the same cycle that it moves `target` to the opposite side of `drive`. The check passes only if `drive` moves one step toward the new target, not the old one. A separate case changes the target halfway through a period and checks that the next step still arrives when the original period completes.

// File: rtl/fan_ramp_limiter.sv
module fan_ramp_limiter #(
  parameter int W  = 8,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  target,
  input  logic          ramp_en,
  input  logic          direct_mode,
  input  logic [W-1:0]  max_step,
  input  logic [2:0]    period_sel,
  input  logic          tick_ms,
  output logic [W-1:0]  drive
);

  logic [CW-1:0] ms_cnt;
  logic [CW-1:0] period_ms;

  always_comb begin
    case (period_sel)
      3'd0:    period_ms = CW'(100);
      3'd1:    period_ms = CW'(200);
      3'd2:    period_ms = CW'(300);
      3'd3:    period_ms = CW'(400);
      3'd4:    period_ms = CW'(500);
      3'd5:    period_ms = CW'(800);
      3'd6:    period_ms = CW'(1200);
      default: period_ms = CW'(1600);
    endcase
  end

  wire          limit_on = ramp_en & direct_mode;
  wire          step_due = tick_ms & (ms_cnt >= period_ms - CW'(1));
  wire [W-1:0]  step     = (max_step == '0) ? W'(1) : max_step;
  wire          upward   = target > drive;
  wire [W-1:0]  gap      = upward ? target - drive : drive - target;
  wire [W-1:0]  next_val = (gap <= step) ? target
                         : (upward ? drive + step : drive - step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive  <= '0;
      ms_cnt <= '0;
    end else if (!limit_on) begin
      drive  <= target;
      ms_cnt <= '0;
    end else if (tick_ms) begin
      if (step_due) begin
        drive  <= next_val;
        ms_cnt <= '0;
      end else begin
        ms_cnt <= ms_cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/fan_ramp_limiter_chk.sv
module fan_ramp_limiter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] target,
  input logic         ramp_en,
  input logic         direct_mode,
  input logic [W-1:0] max_step,
  input logic         tick_ms,
  input logic [W-1:0] drive
);

  function automatic logic [W-1:0] span(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic logic [W-1:0] eff(input logic [W-1:0] s);
    return (s == '0) ? W'(1) : s;
  endfunction

  wire act = ramp_en & direct_mode;

  AST_RESET_ZERO: assert property (@(posedge clk) $rose(rst_n) |-> drive == '0); // R1

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> drive == $past(target)); // R2 R3

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> span(drive, $past(drive)) <= eff($past(max_step))); // R4

  AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (act && drive <= target) |=> drive <= $past(target)); // R5

  AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (act && drive >= target) |=> drive >= $past(target)); // R5

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !tick_ms) |=> $stable(drive)); // R8

endmodule

bind fan_ramp_limiter fan_ramp_limiter_chk #(.W(W)) u_chk (.*);

// File: tb/tb_fan_ramp_limiter.sv
`timescale 1ns/1ps
module tb_fan_ramp_limiter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] target;
  logic       ramp_en;
  logic       direct_mode;
  logic [7:0] max_step;
  logic [2:0] period_sel;
  logic       tick_ms;
  logic [7:0] drive;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  int         rid_q[$];
  bit         done = 1'b0;

  always #5 clk = ~clk;

  fan_ramp_limiter dut (
    .clk(clk), .rst_n(rst_n), .target(target), .ramp_en(ramp_en),
    .direct_mode(direct_mode), .max_step(max_step), .period_sel(period_sel),
    .tick_ms(tick_ms), .drive(drive)
  );

  task automatic expect_drive(input logic [7:0] e, input int rid);
    exp_q.push_back(e);
    rid_q.push_back(rid);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
      @(negedge clk);
    end
  endtask

  function automatic int period_of(input int code);
    case (code)
      0: return 100;
      1: return 200;
      2: return 300;
      3: return 400;
      4: return 500;
      5: return 800;
      6: return 1200;
      default: return 1600;
    endcase
  endfunction

  // monitor: compares queued expectations just after each falling edge
  always begin
    @(negedge clk);
    #1;
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      int r;
      e = exp_q.pop_front();
      r = rid_q.pop_front();
      n_vec++;
      if (drive !== e) begin
        n_bad++;
        $display("FAIL R%0d: drive=%h expected=%h at %0t", r, drive, e, $time);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur;
    rst_n = 1'b0; target = 8'h00; ramp_en = 1'b0; direct_mode = 1'b0;
    max_step = 8'h00; period_sel = 3'd3; tick_ms = 1'b0;
    repeat (3) @(negedge clk);
    expect_drive(8'h00, 1);                       // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    expect_drive(8'h00, 1);                       // R1 after release

    target = 8'hA0;
    @(negedge clk);
    expect_drive(8'hA0, 2);                       // R2 direct copy

    ramp_en = 1'b1; target = 8'h10;
    @(negedge clk);
    expect_drive(8'h10, 3);                       // R3 non-direct mode passes

    direct_mode = 1'b1; period_sel = 3'd0; max_step = 8'h20; target = 8'h80;
    @(negedge clk);
    expect_drive(8'h10, 11);                      // R11 no jump on enable
    ticks(99);
    expect_drive(8'h10, 8);                       // R8 no step before period ends
    ticks(1);
    expect_drive(8'h30, 4);                       // R4 bounded step
    ticks(100);
    expect_drive(8'h50, 4);                       // R4
    ticks(100);
    expect_drive(8'h70, 4);                       // R4
    ticks(100);
    expect_drive(8'h80, 5);                       // R5 lands on target
    ticks(100);
    expect_drive(8'h80, 5);                       // R5 stays put

    target = 8'h05; max_step = 8'h00;
    @(negedge clk);
    ticks(100);
    expect_drive(8'h7F, 6);                       // R6 zero step acts as one

    max_step = 8'h10;
    ticks(50);
    target = 8'h00;
    ticks(50);
    expect_drive(8'h6F, 9);                       // R9 period not restarted
    ticks(50);
    expect_drive(8'h6F, 8);                       // R8 counter reloaded
    ticks(49);
    target = 8'hFF; tick_ms = 1'b1;
    @(negedge clk);
    tick_ms = 1'b0;
    @(negedge clk);
    expect_drive(8'h7F, 10);                      // R10 step uses new target

    target = 8'hC0;
    ticks(30);
    ramp_en = 1'b0;
    @(negedge clk);
    expect_drive(8'hC0, 2);                       // R2 disable mid-ramp jumps

    ramp_en = 1'b1; target = 8'h00; max_step = 8'h08;
    @(negedge clk);
    expect_drive(8'hC0, 11);                      // R11
    ticks(99);
    expect_drive(8'hC0, 11);                      // R11 full period after enable
    ticks(1);
    expect_drive(8'hB8, 11);                      // R11

    max_step = 8'h01;
    cur = 8'hB8;
    for (int c = 0; c < 8; c++) begin
      period_sel = 3'(c);
      ticks(period_of(c) - 1);
      expect_drive(cur, 7);                       // R7 one tick short
      ticks(1);
      cur = cur - 8'h01;
      expect_drive(cur, 7);                       // R7 step at period
    end

    direct_mode = 1'b0; target = 8'h55;
    @(negedge clk);
    expect_drive(8'h55, 3);                       // R3 leaving direct mode

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule